// File: doc/BRIEF.md
# Data-Link Bit-Oriented Code Loopback Controller

This block watches the serial facility data link of an extended-superframe T1 receiver and recognises the bit-oriented messages carried on it. Each message is a code word of eight bits followed by eight ones, and it is sent back-to-back for as long as the far end wants the message to stand. The block decides when a code has really arrived and when it has gone away. It reports both events as one-cycle pulses and shows the code that is currently standing.

From the arrival and removal of the codes it drives two loopback enables. A payload loopback starts as soon as its request is confirmed. A line loopback starts only once its request has stopped, so the request itself is never looped back to the far end. Specific release codes, a universal release code and an alarm-indication-signal (AIS) flag each end a loopback. A retention code only confirms that a loopback is present. Data-link bits enter one at a time under a valid strobe, so the link may be gapped at any rate below the clock.

Top module: `boc_loopback_ctrl`

## Requirements
- R1: Only bits with `dl_valid_i` high are taken; `dl_bit_i` is ignored while it is low. A code is seen when the last 16 taken bits are a word `w` (first-taken bit = w[7]) followed by eight ones, with w[7]=0, w[0]=0 and w[6:1] not all zero. Words with w[6:1] all zero are never reported.
- R2: Taken bits are grouped into intervals of 16, counted from reset. A code becomes standing when it has been seen in at least 7 of the last 10 intervals. At that point `code_valid_o` pulses for one cycle and `code_o` shows the word.
- R3: A standing code is removed after 10 consecutive intervals in which it is not seen. At that point `code_removed_o` pulses for one cycle and `code_o` returns to 0. If a different code becomes standing first, both pulses fire together.
- R4: When payload-activate (00010100) becomes standing, `payload_lb_o` is set and `line_lb_o` is cleared.
- R5: When line-activate (00001110) becomes standing, neither enable changes. When line-activate is removed, `line_lb_o` is set and `payload_lb_o` is cleared.
- R6: When line-deactivate (00111000) becomes standing, `line_lb_o` is cleared. When payload-deactivate (00110010) becomes standing, `payload_lb_o` is cleared.
- R7: When universal-deactivate (00100100) becomes standing, both enables are cleared.
- R8: A cycle with `ais_i` high clears both enables at the next clock edge. AIS does not affect the code state.
- R9: `retain_o` is high while loopback-retention (00101010) is the standing code. That code changes neither enable.
- R10: Other codes are reported as standing but leave the enables alone. `line_lb_o` and `payload_lb_o` are never high together.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dl_bit_i | input | 1 | Data-link bit |
| dl_valid_i | input | 1 | Strobe qualifying `dl_bit_i` |
| ais_i | input | 1 | AIS indication from the receive framer |
| code_o | output | 8 | Standing code word, 0 when none |
| code_valid_o | output | 1 | One-cycle pulse: a code became standing |
| code_removed_o | output | 1 | One-cycle pulse: the standing code went away |
| line_lb_o | output | 1 | Line loopback enable |
| payload_lb_o | output | 1 | Payload loopback enable |
| retain_o | output | 1 | Retention code is standing |

## Verification
The bench drives every strobed bit with the inverse bit parked on the line between strobes. A design that sampled without the strobe would see corrupted words and never validate. It stops one interval short of each threshold, after 6 hits and after 9 idle intervals, to catch off-by-one counters that declare or drop a code too early. It also feeds a 7-of-10 pattern with gaps, which a design needing consecutive hits would miss. It runs each activate/release pair, and it replaces one standing code with another: a design that acted on line-activate on arrival, let both enables stand, or ignored replacement removals would leave the wrong enable set. An all-zero word and an unknown word check that reporting and loopback action are kept apart.

// File: rtl/boc_pkg.sv
package boc_pkg;
    localparam int WORD_W  = 8;
    localparam int FRAME_W = 16;

    localparam logic [WORD_W-1:0] W_LINE_UP   = 8'b00001110;
    localparam logic [WORD_W-1:0] W_LINE_DN   = 8'b00111000;
    localparam logic [WORD_W-1:0] W_PAY_UP    = 8'b00010100;
    localparam logic [WORD_W-1:0] W_PAY_DN    = 8'b00110010;
    localparam logic [WORD_W-1:0] W_ALL_DN    = 8'b00100100;
    localparam logic [WORD_W-1:0] W_HOLD      = 8'b00101010;
endpackage

// File: rtl/boc_frame_align.sv
module boc_frame_align
    import boc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_i,
    input  logic              valid_i,
    output logic              hit_o,
    output logic [WORD_W-1:0] word_o,
    output logic              iv_end_o
);
    localparam int CNT_W = $clog2(FRAME_W);

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
    } fa_t;

    fa_t q, d;
    logic [FRAME_W-1:0] sr_nx;

    always_comb begin
        d        = q;
        sr_nx    = {q.sr[FRAME_W-2:0], bit_i};
        hit_o    = valid_i
                 && (sr_nx[WORD_W-1:0] == {WORD_W{1'b1}})
                 && !sr_nx[FRAME_W-1]
                 && !sr_nx[WORD_W]
                 && (|sr_nx[FRAME_W-2:WORD_W+1]);
        word_o   = sr_nx[FRAME_W-1:WORD_W];
        iv_end_o = valid_i && (q.cnt == CNT_W'(FRAME_W-1));
        if (valid_i) begin
            d.sr  = sr_nx;
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/boc_code_integrator.sv
module boc_code_integrator
    import boc_pkg::*;
#(
    parameter int WINDOW = 10,
    parameter int HITS   = 7,
    parameter int MISSES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              iv_end_i,
    output logic              act_o,
    output logic [WORD_W-1:0] act_code_o,
    output logic              val_p_o,
    output logic              rem_p_o,
    output logic [WORD_W-1:0] rem_code_o
);
    localparam int MISS_W = $clog2(MISSES + 1);

    typedef struct packed {
        logic [WORD_W-1:0] cand;
        logic              cand_hit;
        logic [WINDOW-1:0] hist;
        logic              act;
        logic [WORD_W-1:0] act_code;
        logic              act_hit;
        logic [MISS_W-1:0] miss;
        logic              val_p;
        logic              rem_p;
        logic [WORD_W-1:0] rem_code;
    } ci_t;

    ci_t q, d;
    int  hits_now;

    always_comb begin
        d        = q;
        d.val_p  = 1'b0;
        d.rem_p  = 1'b0;
        hits_now = 0;
        if (hit_i) begin
            if (word_i != q.cand) begin
                d.cand = word_i;
                d.hist = '0;
            end
            d.cand_hit = 1'b1;
            if (q.act && (word_i == q.act_code)) d.act_hit = 1'b1;
        end
        if (iv_end_i) begin
            d.hist     = {d.hist[WINDOW-2:0], d.cand_hit};
            d.cand_hit = 1'b0;
            hits_now   = $countones(d.hist);
            if (q.act) begin
                if (d.act_hit) begin
                    d.miss = '0;
                end else if (int'(q.miss) + 1 >= MISSES) begin
                    d.act      = 1'b0;
                    d.miss     = '0;
                    d.rem_p    = 1'b1;
                    d.rem_code = q.act_code;
                end else begin
                    d.miss = q.miss + 1'b1;
                end
            end
            d.act_hit = 1'b0;
            if (hits_now >= HITS && !(d.act && d.act_code == d.cand)) begin
                if (d.act) begin
                    d.rem_p    = 1'b1;
                    d.rem_code = q.act_code;
                end
                d.act      = 1'b1;
                d.act_code = d.cand;
                d.miss     = '0;
                d.val_p    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign act_o      = q.act;
    assign act_code_o = q.act_code;
    assign val_p_o    = q.val_p;
    assign rem_p_o    = q.rem_p;
    assign rem_code_o = q.rem_code;
endmodule

// File: rtl/boc_lb_policy.sv
module boc_lb_policy
    import boc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              val_p_i,
    input  logic [WORD_W-1:0] act_code_i,
    input  logic              rem_p_i,
    input  logic [WORD_W-1:0] rem_code_i,
    input  logic              ais_i,
    output logic              line_o,
    output logic              pay_o
);
    typedef struct packed {
        logic line;
        logic pay;
    } lp_t;

    lp_t q, d;

    always_comb begin
        d = q;
        if (rem_p_i && rem_code_i == W_LINE_UP) begin
            d.line = 1'b1;
            d.pay  = 1'b0;
        end
        if (val_p_i) begin
            case (act_code_i)
                W_PAY_UP:  begin d.pay = 1'b1; d.line = 1'b0; end
                W_LINE_DN: d.line = 1'b0;
                W_PAY_DN:  d.pay  = 1'b0;
                W_ALL_DN:  begin d.pay = 1'b0; d.line = 1'b0; end
                default:   ;
            endcase
        end
        if (ais_i) begin
            d.line = 1'b0;
            d.pay  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign line_o = q.line;
    assign pay_o  = q.pay;
endmodule

// File: rtl/boc_loopback_ctrl.sv
module boc_loopback_ctrl
    import boc_pkg::*;
#(
    parameter int WINDOW = 10,
    parameter int HITS   = 7,
    parameter int MISSES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dl_bit_i,
    input  logic              dl_valid_i,
    input  logic              ais_i,
    output logic [WORD_W-1:0] code_o,
    output logic              code_valid_o,
    output logic              code_removed_o,
    output logic              line_lb_o,
    output logic              payload_lb_o,
    output logic              retain_o
);
    logic              fa_hit;
    logic [WORD_W-1:0] fa_word;
    logic              fa_end;
    logic              ci_act;
    logic [WORD_W-1:0] ci_code;
    logic [WORD_W-1:0] ci_rem_code;

    boc_frame_align u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_i    (dl_bit_i),
        .valid_i  (dl_valid_i),
        .hit_o    (fa_hit),
        .word_o   (fa_word),
        .iv_end_o (fa_end)
    );

    boc_code_integrator #(
        .WINDOW (WINDOW),
        .HITS   (HITS),
        .MISSES (MISSES)
    ) u_integ (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (fa_hit),
        .word_i     (fa_word),
        .iv_end_i   (fa_end),
        .act_o      (ci_act),
        .act_code_o (ci_code),
        .val_p_o    (code_valid_o),
        .rem_p_o    (code_removed_o),
        .rem_code_o (ci_rem_code)
    );

    boc_lb_policy u_policy (
        .clk        (clk),
        .rst_n      (rst_n),
        .val_p_i    (code_valid_o),
        .act_code_i (ci_code),
        .rem_p_i    (code_removed_o),
        .rem_code_i (ci_rem_code),
        .ais_i      (ais_i),
        .line_o     (line_lb_o),
        .pay_o      (payload_lb_o)
    );

    assign code_o   = ci_act ? ci_code : '0;
    assign retain_o = ci_act && (ci_code == W_HOLD);
endmodule

// File: rtl/boc_loopback_chk.sv
module boc_loopback_chk
    import boc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              dl_valid_i,
    input logic              ais_i,
    input logic [WORD_W-1:0] code_o,
    input logic              code_valid_o,
    input logic              code_removed_o,
    input logic              line_lb_o,
    input logic              payload_lb_o
);
    // R10: enables never overlap
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_lb_o && payload_lb_o));

    // R8: AIS clears both enables at the next edge
    a_r8_ais_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ais_i |=> (!line_lb_o && !payload_lb_o));

    // R5: line loopback rises only after a removal pulse
    a_r5_line_on_removal: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_lb_o) |-> $past(code_removed_o));

    // R4: payload loopback rises only on a confirmed payload-activate
    a_r4_pay_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(payload_lb_o) |-> ($past(code_valid_o) && $past(code_o) == W_PAY_UP));

    // R1: nothing changes in the code state without a strobed bit
    a_r1_no_strobe_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !dl_valid_i |=> ($stable(code_o) && !code_valid_o && !code_removed_o));

    // R2: a reported code is never the all-zero word
    a_r2_valid_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid_o |-> (code_o != '0));
endmodule

bind boc_loopback_ctrl boc_loopback_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .dl_valid_i     (dl_valid_i),
    .ais_i          (ais_i),
    .code_o         (code_o),
    .code_valid_o   (code_valid_o),
    .code_removed_o (code_removed_o),
    .line_lb_o      (line_lb_o),
    .payload_lb_o   (payload_lb_o)
);

// File: tb/boc_loopback_ctrl_bench.sv
module boc_loopback_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    localparam logic [7:0] C_LINE_UP = 8'b00001110;
    localparam logic [7:0] C_LINE_DN = 8'b00111000;
    localparam logic [7:0] C_PAY_UP  = 8'b00010100;
    localparam logic [7:0] C_PAY_DN  = 8'b00110010;
    localparam logic [7:0] C_ALL_DN  = 8'b00100100;
    localparam logic [7:0] C_HOLD    = 8'b00101010;
    localparam logic [7:0] C_OTHER   = 8'b01000100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dl_bit = 1'b0;
    logic       dl_valid = 1'b0;
    logic       ais = 1'b0;
    logic [7:0] code;
    logic       cval, crem, line_lb, pay_lb, retain;

    int checks = 0;
    int errors = 0;
    int nval = 0;
    int nrem = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boc_loopback_ctrl u_boc_loopback_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .dl_bit_i       (dl_bit),
        .dl_valid_i     (dl_valid),
        .ais_i          (ais),
        .code_o         (code),
        .code_valid_o   (cval),
        .code_removed_o (crem),
        .line_lb_o      (line_lb),
        .payload_lb_o   (pay_lb),
        .retain_o       (retain)
    );

    always @(negedge clk) begin
        if (cval) nval++;
        if (crem) nrem++;
    end

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        dl_bit   = b;
        dl_valid = 1'b1;
        @(negedge clk);
        dl_valid = 1'b0;
        dl_bit   = ~b;
    endtask

    task automatic send_code(input logic [7:0] w, input int n);
        for (int k = 0; k < n; k++) begin
            for (int i = 7; i >= 0; i--) send_bit(w[i]);
            for (int i = 0; i < 8; i++) send_bit(1'b1);
        end
    endtask

    task automatic send_idle(input int n);
        for (int k = 0; k < n; k++)
            for (int j = 0; j < 2; j++)
                for (int i = 7; i >= 0; i--) send_bit(8'h7E >> i);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v0, r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R11 reset state
        check("R11 code", int'(code), 0);
        check("R11 line", int'(line_lb), 0);
        check("R11 payload", int'(pay_lb), 0);
        check("R11 retain", int'(retain), 0);
        check("R11 pulses", nval + nrem, 0);

        // R2 threshold, R4 payload activate
        send_code(C_PAY_UP, 6); settle();
        check("R2 six hits not enough", nval, 0);
        send_code(C_PAY_UP, 1); settle();
        check("R2 seventh hit validates", nval, 1);
        check("R2 code shown", int'(code), int'(C_PAY_UP));
        check("R4 payload on", int'(pay_lb), 1);
        check("R4 line off", int'(line_lb), 0);

        // R3 removal
        send_idle(9); settle();
        check("R3 nine misses keep code", nrem, 0);
        check("R3 code still shown", int'(code), int'(C_PAY_UP));
        send_idle(1); settle();
        check("R3 tenth miss removes", nrem, 1);
        check("R3 code cleared", int'(code), 0);
        check("R3 payload unaffected by removal", int'(pay_lb), 1);

        // R5 line activate acts on removal
        send_code(C_LINE_UP, 10); settle();
        check("R5 line code valid", nval, 2);
        check("R5 line not on arrival", int'(line_lb), 0);
        check("R5 payload kept on arrival", int'(pay_lb), 1);
        send_idle(10); settle();
        check("R5 line code removed", nrem, 2);
        check("R5 line on after removal", int'(line_lb), 1);
        check("R10 payload cleared by line", int'(pay_lb), 0);

        // R9 retention
        send_code(C_HOLD, 8); settle();
        check("R9 retain high", int'(retain), 1);
        check("R9 code", int'(code), int'(C_HOLD));
        check("R9 line kept", int'(line_lb), 1);
        send_idle(10); settle();
        check("R9 retain low after removal", int'(retain), 0);
        check("R9 line kept after removal", int'(line_lb), 1);

        // R6 line deactivate
        send_code(C_LINE_DN, 7); settle();
        check("R6 line off", int'(line_lb), 0);
        send_idle(10); settle();

        // R6 payload deactivate with code replacement
        send_code(C_PAY_UP, 7); settle();
        check("R4 payload on again", int'(pay_lb), 1);
        v0 = nval; r0 = nrem;
        send_code(C_PAY_DN, 7); settle();
        check("R6 payload off", int'(pay_lb), 0);
        check("R3 replacement removal pulse", nrem - r0, 1);
        check("R3 replacement valid pulse", nval - v0, 1);
        send_idle(10); settle();

        // R7 universal release of line
        send_code(C_LINE_UP, 7); send_idle(10); settle();
        check("R5 line on", int'(line_lb), 1);
        send_code(C_ALL_DN, 7); settle();
        check("R7 line off", int'(line_lb), 0);
        send_idle(10);
        // R7 universal release of payload
        send_code(C_PAY_UP, 7); settle();
        send_code(C_ALL_DN, 7); settle();
        check("R7 payload off", int'(pay_lb), 0);
        send_idle(10); settle();

        // R8 AIS
        send_code(C_PAY_UP, 7); settle();
        check("R8 payload on before AIS", int'(pay_lb), 1);
        @(negedge clk) ais = 1'b1;
        @(negedge clk) ais = 1'b0;
        settle();
        check("R8 payload off", int'(pay_lb), 0);
        check("R8 code unaffected", int'(code), int'(C_PAY_UP));
        send_idle(10); settle();

        // R2 seven of ten with gaps
        v0 = nval;
        send_code(C_LINE_DN, 2); send_idle(1);
        send_code(C_LINE_DN, 2); send_idle(1);
        send_code(C_LINE_DN, 2); send_idle(1); settle();
        check("R2 six of nine not enough", nval - v0, 0);
        send_code(C_LINE_DN, 1); settle();
        check("R2 seven of ten validates", nval - v0, 1);
        send_idle(10); settle();

        // R10 unknown code, R1 zero word
        send_code(C_PAY_UP, 7); settle();
        v0 = nval;
        send_code(C_OTHER, 7); settle();
        check("R10 unknown code reported", int'(code), int'(C_OTHER));
        check("R10 payload kept", int'(pay_lb), 1);
        v0 = nval; r0 = nrem;
        send_code(8'h00, 10); settle();
        check("R1 zero word not reported", nval - v0, 0);
        check("R1 zero word counts as miss", nrem - r0, 1);
        check("R1 code cleared", int'(code), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule